// File: doc/BRIEF.md
# Privilege-gated split 64-bit cycle counter

This block keeps a free-running cycle count, one step per clock, stored as a low half and a high half of `DW` bits each. The default is 32, so the two halves make a 64-bit count. Software sees the halves as two separate words on a small register bus. It can read either word in any processor mode. It can overwrite a word only while the mode input shows a privileged mode. No single access spans both halves.

A debug-port reset clears the whole count and the violation flag. The core reset does not reach this block. A write that arrives without privilege is dropped, and it raises a one-cycle violation pulse that a supervisor can monitor.

Top module: `cyc_ctr64`

## Requirements
- R1: With no accepted write, every rising clock edge adds one to the concatenated value {high, low}, treated as a 2*DW-bit number. The carry out of the low half enters the high half on the same edge.
- R2: Word address LO_ADDR (default 0) selects the low half and HI_ADDR (default 1) selects the high half. A read from any other address returns zero. A write to any other address changes nothing. No access reaches both halves.
- R3: While `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows the present value of the addressed half, in every mode. When no read is in progress, `bus_rdata` is zero.
- R4: The mode encoding is 2'b01 supervisor, 2'b10 emulator, 2'b00 user and 2'b11 reserved. Only 2'b01 and 2'b10 allow writes.
- R5: A privileged write to the low half loads `bus_wdata` into the low half at the next edge. On that edge the high half still takes the carry from the old low value.
- R6: A privileged write to the high half loads `bus_wdata` into the high half at the next edge. On that edge the low half still increments, and its carry is discarded.
- R7: A write to either half in an unprivileged mode leaves both halves counting exactly as if there had been no access.
- R8: `priv_viol` is 1 for exactly the cycle after each rejected write to a counter address, and 0 otherwise.
- R9: While `dbg_rst_n` is low, the count and `priv_viol` are zero, without waiting for a clock edge. After release, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst_n | input | 1 | Debug-port reset, active low, asynchronous |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| priv_mode | input | 2 | Current processor mode |
| bus_rdata | output | DW | Read data (combinational) |
| priv_viol | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench builds the block with DW=8 and AW=4. With these values the low half wraps every 256 cycles, so carries into the high half happen many times during an ordinary random run. Preloading the high half close to its top value also makes wrap of the full 16-bit count reachable in a few cycles. The 4-bit address field leaves fourteen unmapped addresses, which the random stimulus hits with both reads and writes in all four modes.

// File: rtl/cyc_ctr64.sv
module cyc_ctr64 #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 1
) (
  input  logic          clk,
  input  logic          dbg_rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [1:0]    priv_mode,
  output logic [DW-1:0] bus_rdata,
  output logic          priv_viol
);
  localparam logic [AW-1:0] A_LO = AW'(LO_ADDR);
  localparam logic [AW-1:0] A_HI = AW'(HI_ADDR);
  localparam int CW = 2 * DW;

  logic [DW-1:0] lo_q, hi_q;
  logic          viol_q;

  wire is_lo  = bus_addr == A_LO;
  wire is_hi  = bus_addr == A_HI;
  wire priv   = (priv_mode == 2'b01) || (priv_mode == 2'b10);
  wire wr_hit = bus_sel && bus_wr && (is_lo || is_hi);
  wire wr_lo  = wr_hit && priv && is_lo;
  wire wr_hi  = wr_hit && priv && is_hi;
  wire reject = wr_hit && !priv;

  wire [DW:0] lo_inc = {1'b0, lo_q} + {{DW{1'b0}}, 1'b1};
  wire [DW-1:0] hi_inc = hi_q + {{(DW-1){1'b0}}, lo_inc[DW]};

  always_ff @(posedge clk or negedge dbg_rst_n) begin
    if (!dbg_rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      viol_q <= 1'b0;
    end else begin
      lo_q   <= wr_lo ? bus_wdata : lo_inc[DW-1:0];
      hi_q   <= wr_hi ? bus_wdata : hi_inc;
      viol_q <= reject;
    end
  end

  assign priv_viol = viol_q;
  assign bus_rdata = (bus_sel && !bus_wr) ? (is_lo ? lo_q : (is_hi ? hi_q : '0)) : '0;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    !(wr_lo || wr_hi) |=> ({hi_q, lo_q} - $past({hi_q, lo_q})) == CW'(1)); // R1
  AST_REJECT_NOP: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    reject |=> (lo_q - $past(lo_q)) == DW'(1)); // R7
  AST_WR_LO_LOAD: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    wr_lo |=> lo_q == $past(bus_wdata)); // R5
  AST_WR_HI_LOAD: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    wr_hi |=> hi_q == $past(bus_wdata)); // R6
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    reject |=> priv_viol); // R8
  AST_VIOL_CLR: assert property (@(posedge clk) disable iff (!dbg_rst_n)
    !reject |=> !priv_viol); // R8
  always_comb if (!dbg_rst_n) AST_RST_CLEAR: assert (!priv_viol); // R9
endmodule

// File: tb/cyc_ctr64_tb.sv
module cyc_ctr64_tb;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          dbg_rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [1:0]    priv_mode = 2'b00;
  logic [DW-1:0] bus_rdata;
  logic          priv_viol;

  int checks = 0, fails = 0;
  bit done = 0;
  string prev_tag = "R9";

  logic [DW-1:0] exp_lo, exp_hi;
  logic          exp_viol;

  always #10 clk = ~clk;

  cyc_ctr64 #(.DW(DW), .AW(AW), .LO_ADDR(0), .HI_ADDR(1)) u_dut (
    .clk(clk), .dbg_rst_n(dbg_rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .priv_mode(priv_mode),
    .bus_rdata(bus_rdata), .priv_viol(priv_viol));

  function automatic logic is_priv(input logic [1:0] m);
    return m == 2'b01 || m == 2'b10;
  endfunction

  // Reference model built from R1, R2, R4-R9
  always @(posedge clk or negedge dbg_rst_n) begin
    if (!dbg_rst_n) begin
      exp_lo <= '0; exp_hi <= '0; exp_viol <= 1'b0;
    end else begin
      logic [2*DW-1:0] nxt;
      logic hit;
      hit = bus_sel && bus_wr && (bus_addr == 0 || bus_addr == 1);
      nxt = {exp_hi, exp_lo} + 1;
      if (hit && is_priv(priv_mode) && bus_addr == 0) nxt[DW-1:0] = bus_wdata;
      if (hit && is_priv(priv_mode) && bus_addr == 1) nxt[2*DW-1:DW] = bus_wdata;
      exp_lo <= nxt[DW-1:0];
      exp_hi <= nxt[2*DW-1:DW];
      exp_viol <= hit && !is_priv(priv_mode);
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [1:0] m);
    logic [DW-1:0] e;
    string t;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; priv_mode = m;
    #2;
    if (s && !w) begin
      e = (a == 0) ? exp_lo : ((a == 1) ? exp_hi : '0);
      t = (a > 1) ? "R2" : (!is_priv(m) ? "R3" : prev_tag);
      check(32'(bus_rdata), 32'(e), t);
    end else begin
      check(32'(bus_rdata), 32'd0, "R3");
    end
    check(32'(priv_viol), 32'(exp_viol), "R8");
    if (s && w && a < 2) prev_tag = is_priv(m) ? ((a == 0) ? "R5" : "R6") : ((m == 2'b11) ? "R4" : "R7");
    else if (s && w) prev_tag = "R2";
    else prev_tag = "R1";
  endtask

  task automatic dbg_reset();
    @(negedge clk);
    dbg_rst_n = 1'b0; bus_sel = 1'b0;
    #2;
    check(32'(priv_viol), 32'd0, "R9");
    @(negedge clk);
    dbg_rst_n = 1'b1;
    prev_tag = "R9";
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 0;
    #2;
    check(32'(bus_rdata), 32'd0, "R9");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #5;
    check(32'(priv_viol), 32'd0, "R9");
    check(32'(bus_rdata), 32'd0, "R3");
    dbg_reset();
    for (int i = 0; i < 4; i++) step(1, 0, AW'(i % 2), '0, 2'b00);
    // R5 carry from preloaded low half
    step(1, 1, 1, 8'h12, 2'b01);
    step(1, 1, 0, 8'hFE, 2'b10);
    for (int i = 0; i < 4; i++) step(1, 0, AW'(i % 2), '0, 2'b00);
    // R6: high write while low wraps, full wrap of the count
    step(1, 1, 0, 8'hFF, 2'b01);
    step(1, 1, 1, 8'hFF, 2'b01);
    step(1, 0, 0, '0, 2'b00);
    step(1, 0, 1, '0, 2'b00);
    step(1, 1, 0, 8'hFF, 2'b10);
    step(1, 0, 1, '0, 2'b11);
    step(1, 0, 0, '0, 2'b11);
    // R4/R7: rejected writes in user and reserved modes
    step(1, 1, 0, 8'h00, 2'b00);
    step(1, 0, 0, '0, 2'b00);
    step(1, 1, 1, 8'h55, 2'b11);
    step(1, 0, 1, '0, 2'b00);
    step(1, 1, 0, 8'h33, 2'b11);
    step(1, 1, 0, 8'h33, 2'b00);
    step(1, 0, 0, '0, 2'b01);
    // R2: unmapped addresses
    step(1, 1, 5, 8'hAA, 2'b01);
    step(1, 0, 5, '0, 2'b01);
    step(1, 0, 0, '0, 2'b01);
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0, 1, 2: step(1, 0, AW'($urandom % 2), '0, 2'($urandom));
        3:       step(0, 0, AW'($urandom), 8'($urandom), 2'($urandom));
        4:       step(1, 1, 0, 8'($urandom), 2'($urandom));
        5:       step(1, 1, 1, 8'($urandom), 2'($urandom));
        6:       step(1, 0, AW'(2 + $urandom % 14), '0, 2'($urandom));
        default: step(1, 1, AW'(2 + $urandom % 14), 8'($urandom), 2'($urandom));
      endcase
      if (i == 1500) dbg_reset();
    end
    // R9 after random traffic
    dbg_reset();
    step(1, 0, 1, '0, 2'b00);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule